// File: doc/BRIEF.md
# Bank Command Timing Checker

This block watches the command stream sent to one multi-bank DRAM device and flags every command that comes too early, or a row that stays open too long. Commands travel as packets on two channels. The row channel carries activates and precharges. The column channel carries reads, writes, retires and byte-mask packets. The checker keeps saturating cycle counters for each bank and for the whole device. It compares each new command against the spacing rules for that command type.

When a rule is broken, the block raises a single-cycle violation pulse with a code that names the rule. It also reports which banks currently hold an open row. It is a pure observer: it moves no data, models no array, and never holds back a command. A speed-grade input selects the activate-to-column minimum, which is the only rule that differs between grades.

Top module: `bank_cmd_timing_chk`

## Requirements
- R1: After reset all banks read closed, no violation is reported, and every spacing counter is saturated, so the first command of each kind is legal.
- R2: Two packets on the same channel less than 4 cycles apart give code 1. Row packets are ACT and PRE. Column packets are RD, WR, RET and MSK. Opcodes are 1=ACT, 2=PRE, 3=RD, 4=WR, 5=RET, 6=MSK; 0 and 7 are no command.
- R3: A column packet to a closed bank, or an ACT to an already open bank, gives code 2.
- R4: An ACT less than 28 cycles after the previous ACT to the same bank gives code 3.
- R5: An ACT less than 8 cycles after a PRE to the same bank gives code 4.
- R6: An ACT less than 8 cycles after an ACT to any bank gives code 5.
- R7: A PRE less than 20 cycles after the ACT of the same bank gives code 6.
- R8: A PRE less than 8 cycles after a PRE to any bank gives code 7.
- R9: A column packet to a bank sooner than the activate-to-column minimum after that bank's ACT gives code 8. The minimum is 9 cycles when grade is 0 and 7 cycles for any other grade.
- R10: A RET or MSK packet less than 8 cycles after the last WR to any bank gives code 9.
- R11: A PRE less than 4 cycles after the last RD to that bank gives code 10. A PRE less than 4 cycles after the last RET to that bank gives code 11.
- R12: A row left open for the limit in cycles (64 us divided by the clock period) is flagged once with code 12. The flag comes on the cycle exactly that many cycles after its ACT, unless a PRE to that bank arrives on that cycle. A command violation on the same cycle takes precedence.
- R13: The violation pulse and code appear one cycle after the command. When several rules break at once, the lowest code is reported. The open-bank status updates one cycle after ACT or PRE, and a flagged command still updates all state. With no violation the code reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | A command packet starts this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_bank | input | $clog2(NBANK) | Target bank |
| grade | input | 2 | Speed-grade select |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Broken rule, 0 when none |
| bank_open | output | NBANK | One bit per bank, 1 while a row is open |

## Verification
The stream mixes commands placed exactly at each minimum with commands placed one or more cycles short. This separates an off-by-one in a counter from a correct boundary.

Some commands break several rules at once, which shows whether the priority order is respected. Other commands are spaced correctly but go to the wrong bank or to a closed bank, which separates per-bank counters from device-wide ones.

The grade is switched mid-run to show that only the activate-to-column rule follows it. Two long open rows test the open-time limit. One is left to expire, to check that it is flagged once and at the right cycle. The other is closed exactly at the limit, to check that no flag is raised.

// File: rtl/bank_cmd_timing_chk.sv
module bank_cmd_timing_chk #(
  parameter int NBANK      = 32,
  parameter int CLK_PS     = 5000,
  parameter int OPEN_NS    = 64000,
  parameter int T_PKT      = 4,
  parameter int T_RC       = 28,
  parameter int T_RAS      = 20,
  parameter int T_RP       = 8,
  parameter int T_PP       = 8,
  parameter int T_RR       = 8,
  parameter int T_RCD_FAST = 9,
  parameter int T_RCD_SLOW = 7,
  parameter int T_WRR      = 8,
  parameter int T_RDP      = 4,
  parameter int T_RTP      = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_vld,
  input  logic [2:0]                 cmd_op,
  input  logic [$clog2(NBANK)-1:0]   cmd_bank,
  input  logic [1:0]                 grade,
  output logic                       viol,
  output logic [3:0]                 viol_code,
  output logic [NBANK-1:0]           bank_open
);
  localparam int BW       = $clog2(NBANK);
  localparam int CW       = $clog2(T_RC + 1);
  localparam int OPEN_LIM = (OPEN_NS * 1000) / CLK_PS;
  localparam int OW       = $clog2(OPEN_LIM + 2);

  localparam logic [CW-1:0] SAT    = '1;
  localparam logic [CW-1:0] K_PKT  = CW'(T_PKT);
  localparam logic [CW-1:0] K_RC   = CW'(T_RC);
  localparam logic [CW-1:0] K_RAS  = CW'(T_RAS);
  localparam logic [CW-1:0] K_RP   = CW'(T_RP);
  localparam logic [CW-1:0] K_PP   = CW'(T_PP);
  localparam logic [CW-1:0] K_RR   = CW'(T_RR);
  localparam logic [CW-1:0] K_RCDF = CW'(T_RCD_FAST);
  localparam logic [CW-1:0] K_RCDS = CW'(T_RCD_SLOW);
  localparam logic [CW-1:0] K_WRR  = CW'(T_WRR);
  localparam logic [CW-1:0] K_RDP  = CW'(T_RDP);
  localparam logic [CW-1:0] K_RTP  = CW'(T_RTP);
  localparam logic [OW-1:0] K_OPEN  = OW'(OPEN_LIM);
  localparam logic [OW-1:0] K_OPEN1 = OW'(OPEN_LIM + 1);

  localparam logic [2:0] OP_ACT = 3'd1, OP_PRE = 3'd2, OP_RD = 3'd3,
                         OP_WR  = 3'd4, OP_RET = 3'd5, OP_MSK = 3'd6;

  function automatic logic [CW-1:0] inc(input logic [CW-1:0] c);
    return (c == SAT) ? c : c + 1'b1;
  endfunction

  logic [CW-1:0] act_c [NBANK];
  logic [CW-1:0] pre_c [NBANK];
  logic [CW-1:0] rd_c  [NBANK];
  logic [CW-1:0] ret_c [NBANK];
  logic [OW-1:0] open_c[NBANK];
  logic [CW-1:0] row_c, col_c, dact_c, dpre_c, wr_c;
  logic [NBANK-1:0] open_q, expire;

  wire is_act = cmd_vld && cmd_op == OP_ACT;
  wire is_pre = cmd_vld && cmd_op == OP_PRE;
  wire is_rd  = cmd_vld && cmd_op == OP_RD;
  wire is_wr  = cmd_vld && cmd_op == OP_WR;
  wire is_ret = cmd_vld && cmd_op == OP_RET;
  wire is_msk = cmd_vld && cmd_op == OP_MSK;
  wire is_row = is_act || is_pre;
  wire is_col = is_rd || is_wr || is_ret || is_msk;

  wire [CW-1:0] rcd_min = (grade == 2'd0) ? K_RCDF : K_RCDS;
  wire [CW-1:0] b_act   = act_c[cmd_bank];

  logic [11:1] rule;
  logic [3:0]  cmd_code;

  always_comb begin
    rule[1]  = (is_row && row_c < K_PKT) || (is_col && col_c < K_PKT);
    rule[2]  = (is_col && !open_q[cmd_bank]) || (is_act && open_q[cmd_bank]);
    rule[3]  = is_act && b_act < K_RC;
    rule[4]  = is_act && pre_c[cmd_bank] < K_RP;
    rule[5]  = is_act && dact_c < K_RR;
    rule[6]  = is_pre && b_act < K_RAS;
    rule[7]  = is_pre && dpre_c < K_PP;
    rule[8]  = is_col && b_act < rcd_min;
    rule[9]  = (is_ret || is_msk) && wr_c < K_WRR;
    rule[10] = is_pre && rd_c[cmd_bank] < K_RDP;
    rule[11] = is_pre && ret_c[cmd_bank] < K_RTP;
    cmd_code = '0;
    for (int k = 11; k >= 1; k--)
      if (rule[k]) cmd_code = 4'(k);
  end

  always_comb
    for (int i = 0; i < NBANK; i++)
      expire[i] = open_q[i] && open_c[i] == K_OPEN && !(is_pre && cmd_bank == BW'(i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_c <= SAT; col_c <= SAT; dact_c <= SAT; dpre_c <= SAT; wr_c <= SAT;
      open_q <= '0;
      viol <= 1'b0;
      viol_code <= '0;
      for (int i = 0; i < NBANK; i++) begin
        act_c[i] <= SAT; pre_c[i] <= SAT; rd_c[i] <= SAT; ret_c[i] <= SAT;
        open_c[i] <= '0;
      end
    end else begin
      row_c  <= is_row ? CW'(1) : inc(row_c);
      col_c  <= is_col ? CW'(1) : inc(col_c);
      dact_c <= is_act ? CW'(1) : inc(dact_c);
      dpre_c <= is_pre ? CW'(1) : inc(dpre_c);
      wr_c   <= is_wr  ? CW'(1) : inc(wr_c);
      for (int i = 0; i < NBANK; i++) begin
        automatic logic hit = cmd_bank == BW'(i);
        act_c[i] <= (is_act && hit) ? CW'(1) : inc(act_c[i]);
        pre_c[i] <= (is_pre && hit) ? CW'(1) : inc(pre_c[i]);
        rd_c[i]  <= (is_rd  && hit) ? CW'(1) : inc(rd_c[i]);
        ret_c[i] <= (is_ret && hit) ? CW'(1) : inc(ret_c[i]);
        if (is_act && hit) begin
          open_q[i] <= 1'b1;
          open_c[i] <= OW'(1);
        end else begin
          if (is_pre && hit) open_q[i] <= 1'b0;
          if (open_q[i] && open_c[i] != K_OPEN1) open_c[i] <= open_c[i] + 1'b1;
        end
      end
      viol      <= (cmd_code != '0) || (|expire);
      viol_code <= (cmd_code != '0) ? cmd_code : ((|expire) ? 4'd12 : 4'd0);
    end
  end

  assign bank_open = open_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (bank_open == '0 && !viol));

  assert_row_pkt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_row && $past(is_row)) |=> (viol && viol_code == 4'd1));

  assert_col_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && !bank_open[cmd_bank]) |=> (viol && viol_code <= 4'd2));

  assert_act_opens_R13: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> bank_open[$past(cmd_bank)]);

  assert_pre_closes_R13: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> !bank_open[$past(cmd_bank)]);

  assert_code_range_R13: assert property (@(posedge clk) disable iff (!rst_n)
    viol ? (viol_code >= 4'd1 && viol_code <= 4'd12) : (viol_code == 4'd0));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_vld && bank_open == '0 && $past(bank_open) == '0) |=> !viol);
endmodule

// File: tb/bank_cmd_timing_chk_bench.sv
`timescale 1ns/1ps
module bank_cmd_timing_chk_bench;
  localparam int LIM = (64000 * 1000) / 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_vld = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [4:0] cmd_bank = '0;
  logic [1:0] grade = 2'd0;
  logic viol;
  logic [3:0] viol_code;
  logic [31:0] bank_open;

  bank_cmd_timing_chk u_bank_cmd_timing_chk (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .grade(grade), .viol(viol), .viol_code(viol_code),
    .bank_open(bank_open));

  always #2.5 clk = ~clk;

  typedef struct { int cyc; int code; string req; } exp_t;
  exp_t q[$];
  exp_t e;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  localparam logic [2:0] ACT = 3'd1, PRE = 3'd2, RD = 3'd3, WR = 3'd4, RET = 3'd5, MSK = 3'd6;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (mon_en) begin
    if (q.size() > 0 && q[0].cyc == cyc) begin
      e = q.pop_front();
      checks++;
      if (viol !== (e.code != 0) || viol_code != 4'(e.code)) begin
        errors++;
        $display("FAIL %s: cycle %0d viol=%0b code=%0d expected code=%0d",
                 e.req, cyc, viol, viol_code, e.code);
      end
    end else if (viol !== 1'b0) begin
      checks++;
      errors++;
      $display("FAIL R13: cycle %0d unexpected code=%0d expected none", cyc, viol_code);
    end
  end

  task automatic issue(input int t, input logic [2:0] op, input logic [4:0] bank,
                       input int code, input string req);
    while (cyc < t - 1) @(negedge clk);
    cmd_vld = 1'b1; cmd_op = op; cmd_bank = bank;
    q.push_back('{t, code, req});
    @(negedge clk);
    cmd_vld = 1'b0; cmd_op = '0;
  endtask

  task automatic chk_open(input logic [31:0] exp, input string req);
    checks++;
    if (bank_open !== exp) begin
      errors++;
      $display("FAIL %s: bank_open=%h expected %h", req, bank_open, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL R13: watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    int t0, t5, t6;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (viol !== 1'b0 || viol_code !== 4'd0) begin
      errors++;
      $display("FAIL R1: viol=%0b code=%0d expected 0", viol, viol_code);
    end
    chk_open(32'h0, "R1");
    mon_en = 1'b1;
    t0 = cyc + 5;
    issue(t0,      ACT, 0, 0, "R1");
    chk_open(32'h1, "R13");
    issue(t0 + 4,  ACT, 1, 5, "R6");
    issue(t0 + 5,  PRE, 2, 1, "R2");
    issue(t0 + 9,  RD,  0, 0, "R9");
    issue(t0 + 13, WR,  1, 0, "R9");
    issue(t0 + 17, RET, 1, 9, "R10");
    issue(t0 + 21, MSK, 1, 0, "R10");
    issue(t0 + 22, PRE, 0, 0, "R11");
    issue(t0 + 26, ACT, 0, 3, "R4 over R5");
    issue(t0 + 30, PRE, 1, 0, "R8");
    issue(t0 + 34, PRE, 0, 6, "R7 over R8");
    issue(t0 + 38, RD,  0, 2, "R3");
    issue(t0 + 42, ACT, 3, 0, "R6");
    chk_open(32'h8, "R13");
    issue(t0 + 46, ACT, 3, 2, "R3");
    grade = 2'd1;
    issue(t0 + 50, RD,  3, 8, "R9");
    issue(t0 + 53, RD,  3, 1, "R2");
    issue(t0 + 63, RD,  3, 0, "R9");
    issue(t0 + 66, PRE, 3, 10, "R11");
    issue(t0 + 70, ACT, 4, 0, "R5");
    issue(t0 + 77, RET, 4, 0, "R9");
    issue(t0 + 88, RET, 4, 0, "R2");
    issue(t0 + 90, PRE, 4, 11, "R11");
    chk_open(32'h0, "R13");
    t5 = t0 + 100;
    issue(t5, ACT, 5, 0, "R12");
    q.push_back('{t5 + LIM, 12, "R12"});
    chk_open(32'h20, "R12");
    issue(t5 + LIM + 60, PRE, 5, 0, "R12");
    chk_open(32'h0, "R12");
    t6 = t5 + LIM + 70;
    issue(t6, ACT, 6, 0, "R12");
    issue(t6 + LIM, PRE, 6, 0, "R12");
    repeat (20) @(negedge clk);
    chk_open(32'h0, "R12");
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d expected items left, expected 0", q.size());
    end
    finish_run();
  end
endmodule